// File: doc/BRIEF.md
# Register-Triggered Dual-Channel Bus Bridge

This block is an APB slave register file that lets software run single transactions on either of two downstream peripheral ports. Each channel has its own staging registers: a select flag, a direction, a size code, a target address and outgoing data. Software fills these registers first. It then writes the launch register, and the bridge issues one access of one, two or four bytes on the chosen port.

A read returns data that is zero-extended from the low byte lanes and kept in that channel's result register. On a clean completion the channel sets a sticky flag in the status register, and the interrupt line rises. A port error leaves both the flag and the result untouched. Only one access can be outstanding at a time. A launch write that arrives while an access is in flight is dropped.

Top module: `trgbr_bridge`

## Requirements
- R1: After reset, address 0x00 reads 0x000000A1, the status register (0x48) reads 0, no downstream request is active and `irq` is low.
- R2: Channel c stages at offset 0x10+0x18*c: +0x0 select (bit 0 kept), +0x4 direction (bit 0 kept, 1 = read), +0x8 size code (32 bits kept), +0xC address, +0x10 outgoing data. Its result register sits at 0x84+0xC*c. The single-bit registers read back zero-extended. Writes to the version and result registers, and reads of unmapped offsets, return or change nothing (unmapped reads give 0).
- R3: An APB write to 0x04 starts one access on the lowest-numbered channel whose select bit is 1, and channel 0 wins when both are set. If no channel is selected, nothing starts. The request is visible in the cycle after the write's access phase, carrying the staged address and data, `dn_we` = NOT direction bit 0, and `dn_size` = size code bits [1:0].
- R4: Size codes 0, 1 and 3 (1, 2 and 4 bytes) are legal. Any other value, including 2 or any bit above bit 1, makes the launch write issue nothing.
- R5: A request and its address, direction and size stay unchanged until the port returns `dn_ack` or `dn_err`. The request is low in the following cycle.
- R6: A launch write that arrives while any request is outstanding is ignored.
- R7: A successful read loads the result register with the returned data, zero-extended from bits [7:0], [15:0] or [31:0] according to the size code. A write leaves the result register unchanged.
- R8: A successful completion on channel c ORs a 1 into status bit 16+c.
- R9: When `dn_err` is high in the response cycle (even together with `dn_ack`), neither the status flag nor the result register changes.
- R10: An APB write to the status register replaces its whole contents. A completion in the same cycle still ORs its bit in. `irq` equals status bit 16 OR status bit 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 12 | APB byte address within the 4 KiB window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| dn_req | output | 2 | Per-channel request, held until response |
| dn_we | output | 2 | Per-channel write direction |
| dn_addr | output | 64 | Per-channel target address, 32 bits each |
| dn_size | output | 4 | Per-channel size code, 2 bits each |
| dn_wdata | output | 64 | Per-channel outgoing data, 32 bits each |
| dn_rdata | input | 64 | Per-channel returned data, 32 bits each |
| dn_ack | input | 2 | Per-channel successful completion |
| dn_err | input | 2 | Per-channel error completion |
| irq | output | 1 | Completion interrupt |

## Verification
A launch write shows its request in the cycle that follows the write's access phase. The bench therefore samples `dn_req` and the latched fields at the falling edge right after that write. A response driven for one cycle takes effect at the next rising edge: the request drops there, and the status flag, `irq` and the result register change at the same edge. The bench looks at all of them at the falling edge after that edge, with APB reads that return data combinationally during the access phase. Rejected launches (illegal size, no selection, or a launch while busy) are checked at the same falling edge where a request would otherwise have appeared.

// File: rtl/trgbr_pkg.sv
// Shared constants and helpers for the dual-channel triggered bridge.
// Assumes exactly two channels: completion flags sit at status bits 16 and 17.
package trgbr_pkg;
    localparam int AW       = 12;
    localparam int DW       = 32;
    localparam int NCH      = 2;
    localparam int SZW      = 2;
    localparam int DONE_LSB = 16;
    localparam int STAGE_BASE   = 16;
    localparam int STAGE_STRIDE = 24;
    localparam int RES_BASE     = 132;
    localparam int RES_STRIDE   = 12;

    localparam logic [AW-1:0] OFF_VERSION = 12'h000;
    localparam logic [AW-1:0] OFF_LAUNCH  = 12'h004;
    localparam logic [AW-1:0] OFF_STATUS  = 12'h048;
    localparam logic [DW-1:0] VERSION_VAL = 32'h0000_00A1;

    typedef enum int {SLOT_SEL = 0, SLOT_DIR = 1, SLOT_SIZE = 2,
                      SLOT_ADDR = 3, SLOT_DATA = 4} slot_e;

    // Byte offset of one staging slot of one channel.
    function automatic logic [AW-1:0] stage_off(input int ch, input slot_e s);
        return AW'(STAGE_BASE + STAGE_STRIDE * ch + 4 * int'(s));
    endfunction

    // Byte offset of a channel's result register.
    function automatic logic [AW-1:0] res_off(input int ch);
        return AW'(RES_BASE + RES_STRIDE * ch);
    endfunction

    // Size codes 0, 1 and 3 are legal; everything else is refused.
    function automatic logic size_legal(input logic [DW-1:0] code);
        return (code[DW-1:SZW] == '0) && (code[1:0] != 2'b10);
    endfunction

    // Zero-extend returned data from the low lanes used by the size code.
    function automatic logic [DW-1:0] lane_zext(input logic [SZW-1:0] sz,
                                                input logic [DW-1:0] d);
        case (sz)
            2'd0:    return {24'd0, d[7:0]};
            2'd1:    return {16'd0, d[15:0]};
            default: return d;
        endcase
    endfunction
endpackage

// File: rtl/trgbr_launch.sv
// Launch arbiter: turns a launch-register write into at most one channel
// start. The lowest-numbered selected channel claims the launch, even if
// its size code is illegal. Assumes busy_any covers every outstanding request.
module trgbr_launch
    import trgbr_pkg::*;
(
    input  logic           trig,
    input  logic           busy_any,
    input  logic [NCH-1:0] sel,
    input  logic [NCH-1:0] legal,
    output logic [NCH-1:0] launch
);
    logic taken;

    // Priority pick of the first selected channel, gated by idle and legal size.
    always_comb begin
        launch = '0;
        taken  = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (!taken && sel[i]) begin
                taken     = 1'b1;
                launch[i] = trig && !busy_any && legal[i];
            end
        end
    end
endmodule

// File: rtl/trgbr_chan.sv
// One bridge channel: software staging registers, the result register and
// the downstream request master. Assumes launch is only pulsed while idle.
module trgbr_chan
    import trgbr_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_val,
    input  logic           launch,
    output logic           sel_bit,
    output logic           legal,
    output logic           done,
    output logic           dn_req,
    output logic           dn_we,
    output logic [DW-1:0]  dn_addr,
    output logic [SZW-1:0] dn_size,
    output logic [DW-1:0]  dn_wdata,
    input  logic [DW-1:0]  dn_rdata,
    input  logic           dn_ack,
    input  logic           dn_err
);
    localparam logic [AW-1:0] A_SEL  = stage_off(CH, SLOT_SEL);
    localparam logic [AW-1:0] A_DIR  = stage_off(CH, SLOT_DIR);
    localparam logic [AW-1:0] A_SIZE = stage_off(CH, SLOT_SIZE);
    localparam logic [AW-1:0] A_ADDR = stage_off(CH, SLOT_ADDR);
    localparam logic [AW-1:0] A_DATA = stage_off(CH, SLOT_DATA);
    localparam logic [AW-1:0] A_RES  = res_off(CH);

    logic           sel_q, dir_q, busy_q, we_q;
    logic [DW-1:0]  size_q, addr_q, data_q, res_q, oaddr_q, odata_q;
    logic [SZW-1:0] osize_q;
    logic           resp;

    assign resp     = busy_q && (dn_ack || dn_err);
    assign done     = resp && !dn_err;
    assign sel_bit  = sel_q;
    assign legal    = size_legal(size_q);
    assign dn_req   = busy_q;
    assign dn_we    = we_q;
    assign dn_addr  = oaddr_q;
    assign dn_size  = osize_q;
    assign dn_wdata = odata_q;

    // Software staging registers, written by APB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            dir_q  <= 1'b0;
            size_q <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_SEL:   sel_q  <= wr_data[0];
                A_DIR:   dir_q  <= wr_data[0];
                A_SIZE:  size_q <= wr_data;
                A_ADDR:  addr_q <= wr_data;
                A_DATA:  data_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Request master: latch the staged access on launch, hold until response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            we_q    <= 1'b0;
            osize_q <= '0;
            oaddr_q <= '0;
            odata_q <= '0;
        end else if (launch) begin
            busy_q  <= 1'b1;
            we_q    <= !dir_q;
            osize_q <= size_q[SZW-1:0];
            oaddr_q <= addr_q;
            odata_q <= data_q;
        end else if (resp) begin
            busy_q  <= 1'b0;
        end
    end

    // Result register: capture lane-extended data on a clean read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (done && !we_q) begin
            res_q <= lane_zext(osize_q, dn_rdata);
        end
    end

    // Readback of this channel's registers; zero when the address misses.
    always_comb begin
        case (rd_addr)
            A_SEL:   rd_val = {31'd0, sel_q};
            A_DIR:   rd_val = {31'd0, dir_q};
            A_SIZE:  rd_val = size_q;
            A_ADDR:  rd_val = addr_q;
            A_DATA:  rd_val = data_q;
            A_RES:   rd_val = res_q;
            default: rd_val = '0;
        endcase
    end

    // R5
    hold_until_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack && !dn_err |=> dn_req && $stable(dn_addr) &&
        $stable(dn_we) && $stable(dn_size) && $stable(dn_wdata));

    // R5
    drop_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && (dn_ack || dn_err) |=> !dn_req);

    // R7
    write_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_we |=> $stable(res_q));

    // R9
    err_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_err |=> $stable(res_q));
endmodule

// File: rtl/trgbr_bridge.sv
// Top of the dual-channel triggered bridge: APB decode, launch arbitration,
// sticky completion status and interrupt. Assumes 32-bit APB accesses with
// zero wait states; read data is driven combinationally from paddr.
module trgbr_bridge
    import trgbr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [AW-1:0]      paddr,
    input  logic [DW-1:0]      pwdata,
    output logic [DW-1:0]      prdata,
    output logic [NCH-1:0]     dn_req,
    output logic [NCH-1:0]     dn_we,
    output logic [NCH*DW-1:0]  dn_addr,
    output logic [NCH*SZW-1:0] dn_size,
    output logic [NCH*DW-1:0]  dn_wdata,
    input  logic [NCH*DW-1:0]  dn_rdata,
    input  logic [NCH-1:0]     dn_ack,
    input  logic [NCH-1:0]     dn_err,
    output logic               irq
);
    logic           wr_en, trig, st_wr;
    logic [NCH-1:0] sel, legal, launch, done;
    logic [DW-1:0]  ch_rd [NCH];
    logic [DW-1:0]  status_q, status_d, base_rd;

    assign wr_en = psel && penable && pwrite;
    assign trig  = wr_en && (paddr == OFF_LAUNCH);
    assign st_wr = wr_en && (paddr == OFF_STATUS);

    trgbr_launch u_launch (
        .trig     (trig),
        .busy_any (|dn_req),
        .sel      (sel),
        .legal    (legal),
        .launch   (launch)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        trgbr_chan #(.CH(c)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_addr  (paddr),
            .wr_data  (pwdata),
            .rd_addr  (paddr),
            .rd_val   (ch_rd[c]),
            .launch   (launch[c]),
            .sel_bit  (sel[c]),
            .legal    (legal[c]),
            .done     (done[c]),
            .dn_req   (dn_req[c]),
            .dn_we    (dn_we[c]),
            .dn_addr  (dn_addr[c*DW +: DW]),
            .dn_size  (dn_size[c*SZW +: SZW]),
            .dn_wdata (dn_wdata[c*DW +: DW]),
            .dn_rdata (dn_rdata[c*DW +: DW]),
            .dn_ack   (dn_ack[c]),
            .dn_err   (dn_err[c])
        );
    end

    // Next status: software write replaces, completions OR in on top.
    always_comb begin
        status_d = st_wr ? pwdata : status_q;
        for (int i = 0; i < NCH; i++) begin
            status_d[DONE_LSB + i] = status_d[DONE_LSB + i] | done[i];
        end
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign irq = |status_q[DONE_LSB +: NCH];

    // Read mux: bridge-level registers ORed with the channel readbacks.
    always_comb begin
        case (paddr)
            OFF_VERSION: base_rd = VERSION_VAL;
            OFF_STATUS:  base_rd = status_q;
            default:     base_rd = '0;
        endcase
        prdata = base_rd;
        for (int i = 0; i < NCH; i++) prdata = prdata | ch_rd[i];
    end

    // R3
    single_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|dn_req) |-> $onehot(dn_req));

    // R8
    flag_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done[0] |=> status_q[DONE_LSB]);

    // R8
    flag_on_done1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done[1] |=> status_q[DONE_LSB + 1]);
endmodule

// File: tb/trgbr_bridge_test.sv
`timescale 1ns/1ps
module trgbr_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [1:0]  dn_req, dn_we;
    logic [63:0] dn_addr, dn_wdata;
    logic [3:0]  dn_size;
    logic [63:0] dn_rdata = '0;
    logic [1:0]  dn_ack = '0, dn_err = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_status = '0;
    logic [31:0] exp_res [2] = '{32'd0, 32'd0};

    always #4 clk = ~clk;

    trgbr_bridge uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk) penable = 1'b1;
        @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk) begin penable = 1'b1; d = prdata; end
        @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
    endtask

    function automatic logic [11:0] soff(input int ch, input int slot);
        return 12'(16 + 24 * ch + 4 * slot);
    endfunction

    function automatic logic [11:0] roff(input int ch);
        return 12'(132 + 12 * ch);
    endfunction

    function automatic logic legal_size(input logic [31:0] w);
        return (w[31:2] == 0) && (w[1:0] != 2'b10);
    endfunction

    function automatic logic [31:0] zext(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd0) return {24'd0, d[7:0]};
        if (sz == 2'd1) return {16'd0, d[15:0]};
        return d;
    endfunction

    // One transaction: stage, launch, respond, then check the results.
    task automatic txn(input int ch, input bit rd, input logic [31:0] w,
                       input logic [31:0] a, input logic [31:0] wd,
                       input bit er, input bit ak_too, input int dly);
        logic [31:0] rv, v;
        apb_wr(soff(ch, 0), 32'd1);
        apb_wr(soff(1 - ch, 0), 32'd0);
        apb_wr(soff(ch, 1), {31'd0, rd});
        apb_wr(soff(ch, 2), w);
        apb_wr(soff(ch, 3), a);
        apb_wr(soff(ch, 4), wd);
        apb_wr(12'h004, $urandom);
        if (!legal_size(w)) begin
            chk("R4 illegal size issues nothing", {30'd0, dn_req}, 32'd0);
            return;
        end
        chk("R3 request on selected channel", {30'd0, dn_req}, 32'(1 << ch));
        chk("R3 address", dn_addr[ch*32 +: 32], a);
        chk("R3 direction", {31'd0, dn_we[ch]}, {31'd0, !rd});
        chk("R3 size", {30'd0, dn_size[ch*2 +: 2]}, {30'd0, w[1:0]});
        chk("R3 outgoing data", dn_wdata[ch*32 +: 32], wd);
        if (dly > 0) begin
            apb_wr(12'h004, 32'd0);
            chk("R6 launch while busy ignored", {30'd0, dn_req}, 32'(1 << ch));
            chk("R5 address held", dn_addr[ch*32 +: 32], a);
            repeat (dly - 1) @(negedge clk);
        end
        rv = $urandom;
        dn_rdata[ch*32 +: 32] = rv;
        dn_err[ch] = er;
        dn_ack[ch] = er ? ak_too : 1'b1;
        @(negedge clk) begin dn_ack = '0; dn_err = '0; end
        chk("R5 request dropped after response", {30'd0, dn_req}, 32'd0);
        if (!er) begin
            exp_status[16 + ch] = 1'b1;
            if (rd) exp_res[ch] = zext(w[1:0], rv);
        end
        apb_rd(12'h048, v);
        chk(er ? "R9 status after error" : "R8 status after completion", v, exp_status);
        chk("R10 irq", {31'd0, irq}, {31'd0, exp_status[16] | exp_status[17]});
        apb_rd(roff(ch), v);
        chk(er ? "R9 result after error" : (rd ? "R7 read result" : "R7 write keeps result"),
            v, exp_res[ch]);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        apb_rd(12'h000, v); chk("R1 version", v, 32'h0000_00A1);
        apb_rd(12'h048, v); chk("R1 status", v, 32'd0);
        chk("R1 no request", {30'd0, dn_req}, 32'd0);
        chk("R1 irq low", {31'd0, irq}, 32'd0);
        // R2 map, readback, read-only and unmapped
        apb_wr(soff(1, 0), 32'hFFFF_FFFF); apb_rd(soff(1, 0), v); chk("R2 select readback", v, 32'd1);
        apb_wr(soff(0, 2), 32'h1234_5678); apb_rd(soff(0, 2), v); chk("R2 size readback", v, 32'h1234_5678);
        apb_wr(soff(1, 3), 32'hCAFE_0004); apb_rd(soff(1, 3), v); chk("R2 address readback", v, 32'hCAFE_0004);
        apb_wr(12'h000, 32'h5555_5555); apb_rd(12'h000, v); chk("R2 version read-only", v, 32'h0000_00A1);
        apb_wr(roff(0), 32'h7777_7777); apb_rd(roff(0), v); chk("R2 result read-only", v, 32'd0);
        apb_rd(12'h200, v); chk("R2 unmapped reads zero", v, 32'd0);
        // R3 neither selected
        apb_wr(soff(0, 0), 32'd0); apb_wr(soff(1, 0), 32'd0);
        apb_wr(soff(0, 2), 32'd3);
        apb_wr(12'h004, 32'd1);
        chk("R3 no channel selected", {30'd0, dn_req}, 32'd0);
        // R3 both selected: channel 0 wins
        apb_wr(soff(0, 0), 32'd1); apb_wr(soff(1, 0), 32'd1);
        apb_wr(soff(1, 2), 32'd3);
        apb_wr(12'h004, 32'd1);
        chk("R3 channel 0 priority", {30'd0, dn_req}, 32'd1);
        dn_ack[0] = 1'b1;
        @(negedge clk) dn_ack = '0;
        exp_status[16] = 1'b1;
        // Directed corners
        txn(1, 1'b1, 32'd0, 32'h0000_1001, 32'd0, 1'b0, 1'b0, 0);
        txn(0, 1'b1, 32'd1, 32'h0000_2002, 32'd0, 1'b0, 1'b0, 2);
        txn(1, 1'b0, 32'd3, 32'h0000_3000, 32'hDEAD_BEEF, 1'b0, 1'b0, 1);
        txn(0, 1'b1, 32'd3, 32'h0000_4000, 32'd0, 1'b1, 1'b1, 1);
        txn(0, 1'b1, 32'd2, 32'h0000_5000, 32'd0, 1'b0, 1'b0, 0);
        txn(1, 1'b1, 32'h0000_0103, 32'h0000_6000, 32'd0, 1'b0, 1'b0, 0);
        // R10 status replace and irq
        apb_wr(12'h048, 32'h0000_0005); exp_status = 32'h5;
        apb_rd(12'h048, v); chk("R10 status replaced", v, 32'h5);
        chk("R10 irq low after clear", {31'd0, irq}, 32'd0);
        apb_wr(12'h048, 32'h0002_0000); exp_status = 32'h0002_0000;
        chk("R10 irq from bit 17", {31'd0, irq}, 32'd1);
        // Constrained random traffic
        for (int n = 0; n < 60; n++) begin
            int r;
            logic [31:0] w;
            r = int'($urandom % 8);
            w = (r < 2) ? 32'd0 : (r < 4) ? 32'd1 : (r < 6) ? 32'd3 :
                (r == 6) ? 32'd2 : (32'd4 | ($urandom % 64));
            if ($urandom % 6 == 0) begin
                apb_wr(12'h048, 32'd0);
                exp_status = 32'd0;
            end
            txn(int'($urandom % 2), 1'($urandom), w, $urandom, $urandom,
                ($urandom % 5) == 0, 1'($urandom), int'($urandom % 4));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule